// File: doc/BRIEF.md
# Downstream Port Power Controller

This block switches the power of up to three downstream hub ports. The hub's request decoder gives it one-cycle set and clear power commands per port. External power switches report faults on active-low overcurrent lines. The block drives one active-low enable per port. For the hub status logic it keeps, per port, the accepted overcurrent level and a sticky change flag.

Each overcurrent line passes through a debounce filter before it is acted on. A shared divider produces a sampling tick, and a fault counts only after it has been seen on a programmable number of consecutive ticks. An accepted fault removes power. The port stays off after the fault clears and comes back only on a fresh set request.

In ganged operation the ports behave as one group: any set or clear command moves every enable at once, and a fault on any input trips them all. With the two-port select high, the third port is taken out of service.

Top module: `dsp_pwr_ctl`

## Requirements
- R1: After reset every enable output is high (unpowered), and all status and change bits are 0.
- R2: In per-port mode, a set request on port i drives enable i low after the next clock edge, and a clear request drives it high again.
- R3: An overcurrent line (0 = fault) is accepted only after it is seen low on `filt_len` consecutive sampling ticks. A tick occurs every TICK_DIV clocks, and `filt_len` = 0 counts as 1. A low pulse spanning fewer ticks has no effect on any output.
- R4: While a port's fault is accepted, its status bit is 1 and its enable is forced high.
- R5: Each onset of an accepted fault sets the port's change bit. The bit stays set after the fault ends and is cleared only by `chg_clr` for that port.
- R6: Set requests are ignored while a port's fault is accepted. After the fault ends, the port stays unpowered until a new set request arrives.
- R7: In ganged mode, a set or clear on any in-service port applies to all in-service ports. A fault accepted on any in-service input trips every in-service port and sets all their status and change bits.
- R8: In per-port mode, a fault on one port changes no other port's enable, status or change bit.
- R9: With `two_port` high, the third port (index 2) is held unpowered, and its overcurrent input is ignored. Its status and change bits stay 0 in both ganged and per-port mode.
- R10: A clear request wins over a set request on the same port in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_set_req | input | NP | One-cycle power-on request per port |
| pwr_clr_req | input | NP | One-cycle power-off request per port |
| chg_clr | input | NP | Clears the sticky change bit per port |
| oc_in_n | input | NP | Overcurrent inputs, active low |
| gang_en | input | 1 | 1 = ganged operation |
| two_port | input | 1 | 1 = only ports 0 and 1 in service |
| filt_len | input | FILT_W | Consecutive ticks needed to accept a fault |
| pwr_en_n | output | NP | Port power enables, active low |
| oc_stat | output | NP | Accepted overcurrent level per port |
| oc_chg | output | NP | Sticky overcurrent change flag per port |

## Verification
The hardest situation to reach is the exact filter boundary. Whether a pulse trips the port depends on how many sampling ticks it spans, and the tick phase is invisible at the ports. The stimulus holds each fault for whole multiples of TICK_DIV clock edges. A window of k·TICK_DIV edges contains exactly k ticks whatever the phase, so one filter length less is provably ignored and exactly the filter length is provably accepted. The accepted case is then confirmed after release through the sticky change bit and the latched-off enable.

// File: rtl/dsp_pwr_pkg.sv
package dsp_pwr_pkg;

    // Per-port registered state of the power core.
    typedef struct packed {
        logic pwr;    // 1 = port powered
        logic stat;   // accepted overcurrent, registered
        logic chg;    // sticky onset flag
    } port_st_t;

    localparam port_st_t PORT_RST = '{pwr: 1'b0, stat: 1'b0, chg: 1'b0};

endpackage

// File: rtl/dsp_tick_gen.sv
module dsp_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_st_t;

    tick_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == CW'(DIV - 1)) st_d.cnt = '0;
        else                          st_d.cnt = st_q.cnt + CW'(1);
        tick = (st_q.cnt == CW'(DIV - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        if (DIV > 1) begin : g_chk
            // R3: ticks are isolated single-cycle pulses
            a_r3_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/dsp_oc_filter.sv
module dsp_oc_filter #(
    parameter int FILT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              raw,
    input  logic [FILT_W-1:0] len,
    output logic              accepted
);
    typedef struct packed {
        logic [FILT_W-1:0] cnt;
    } flt_st_t;

    flt_st_t           st_q, st_d;
    logic [FILT_W-1:0] lim;

    always_comb begin
        lim  = (len == '0) ? FILT_W'(1) : len;
        st_d = st_q;
        if (tick) begin
            if (!raw)                st_d.cnt = '0;
            else if (st_q.cnt < lim) st_d.cnt = st_q.cnt + FILT_W'(1);
        end
        accepted = (st_q.cnt >= lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: a fault is only accepted as a result of a sampling tick
    a_r3_accept_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(accepted) && $stable(len)) |-> $past(tick));

    // R3: a quiet sample at a tick withdraws acceptance
    a_r3_quiet_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !raw) |=> !accepted);

endmodule

// File: rtl/dsp_port_core.sv
module dsp_port_core
    import dsp_pwr_pkg::*;
#(
    parameter int NP = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] acc,
    input  logic [NP-1:0] set_req,
    input  logic [NP-1:0] clr_req,
    input  logic [NP-1:0] chg_clr,
    input  logic          gang,
    input  logic          two_port,
    output logic [NP-1:0] pwr,
    output logic [NP-1:0] stat,
    output logic [NP-1:0] chg
);
    port_st_t [NP-1:0] st_q, st_d;
    logic     [NP-1:0] used, eff, setv, clrv;

    always_comb begin
        for (int i = 0; i < NP; i++) begin
            used[i] = !(two_port && (i == NP - 1));
        end
        eff  = gang ? ({NP{|(acc & used)}} & used)     : (acc & used);
        setv = gang ? ({NP{|(set_req & used)}} & used) : (set_req & used);
        clrv = gang ? ({NP{|(clr_req & used)}} & used) : (clr_req & used);

        st_d = st_q;
        for (int i = 0; i < NP; i++) begin
            st_d[i].stat = eff[i];
            st_d[i].chg  = used[i] &
                           ((st_q[i].chg & ~chg_clr[i]) | (eff[i] & ~st_q[i].stat));
            if (!used[i] || eff[i] || clrv[i]) st_d[i].pwr = 1'b0;
            else if (setv[i])                  st_d[i].pwr = 1'b1;
        end

        for (int i = 0; i < NP; i++) begin
            pwr[i]  = st_q[i].pwr;
            stat[i] = st_q[i].stat;
            chg[i]  = st_q[i].chg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= {NP{PORT_RST}};
        else        st_q <= st_d;
    end

    generate
        for (genvar g = 0; g < NP; g++) begin : g_chk
            // R4: an accepted fault removes power at the next edge
            a_r4_fault_cuts_power: assert property (@(posedge clk) disable iff (!rst_n)
                eff[g] |=> !st_q[g].pwr);
            // R6: power is only ever applied in answer to a set command
            a_r6_power_needs_set: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(st_q[g].pwr) |-> $past(setv[g]));
            // R5: a new fault always raises the change flag
            a_r5_onset_flags: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(st_q[g].stat) |-> st_q[g].chg);
            // R10: clear beats set
            a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
                clrv[g] |=> !st_q[g].pwr);
        end
    endgenerate

    // R9: the retired port never gets power
    a_r9_retired_off: assert property (@(posedge clk) disable iff (!rst_n)
        two_port |=> !st_q[NP-1].pwr);

endmodule

// File: rtl/dsp_pwr_ctl.sv
module dsp_pwr_ctl #(
    parameter int NP       = 3,
    parameter int FILT_W   = 4,
    parameter int TICK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NP-1:0]     pwr_set_req,
    input  logic [NP-1:0]     pwr_clr_req,
    input  logic [NP-1:0]     chg_clr,
    input  logic [NP-1:0]     oc_in_n,
    input  logic              gang_en,
    input  logic              two_port,
    input  logic [FILT_W-1:0] filt_len,
    output logic [NP-1:0]     pwr_en_n,
    output logic [NP-1:0]     oc_stat,
    output logic [NP-1:0]     oc_chg
);
    logic          tick;
    logic [NP-1:0] raw, acc, pwr;

    always_comb begin
        for (int i = 0; i < NP; i++) begin
            raw[i] = !oc_in_n[i] && !(two_port && (i == NP - 1));
        end
    end

    dsp_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    generate
        for (genvar g = 0; g < NP; g++) begin : g_flt
            dsp_oc_filter #(.FILT_W(FILT_W)) u_flt (
                .clk      (clk),
                .rst_n    (rst_n),
                .tick     (tick),
                .raw      (raw[g]),
                .len      (filt_len),
                .accepted (acc[g])
            );
        end
    endgenerate

    dsp_port_core #(.NP(NP)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .set_req  (pwr_set_req),
        .clr_req  (pwr_clr_req),
        .chg_clr  (chg_clr),
        .gang     (gang_en),
        .two_port (two_port),
        .pwr      (pwr),
        .stat     (oc_stat),
        .chg      (oc_chg)
    );

    assign pwr_en_n = ~pwr;

endmodule

// File: tb/dsp_pwr_ctl_test.sv
module dsp_pwr_ctl_test;
    localparam int NP = 3;
    localparam int FW = 4;
    localparam int DV = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pwr_set_req = '0, pwr_clr_req = '0, chg_clr = '0;
    logic [NP-1:0] oc_in_n = '1;
    logic          gang_en = 1'b0, two_port = 1'b0;
    logic [FW-1:0] filt_len = FW'(3);
    logic [NP-1:0] pwr_en_n, oc_stat, oc_chg;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        string        tag;
        logic [NP-1:0] en_n;
        logic [NP-1:0] st;
        logic [NP-1:0] ch;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    dsp_pwr_ctl #(.NP(NP), .FILT_W(FW), .TICK_DIV(DV)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_set_req(pwr_set_req), .pwr_clr_req(pwr_clr_req),
        .chg_clr(chg_clr), .oc_in_n(oc_in_n), .gang_en(gang_en), .two_port(two_port),
        .filt_len(filt_len), .pwr_en_n(pwr_en_n), .oc_stat(oc_stat), .oc_chg(oc_chg)
    );

    // Monitor: pops expectations and compares away from the rising edge.
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (pwr_en_n !== e.en_n || oc_stat !== e.st || oc_chg !== e.ch) begin
                    errors++;
                    $display("FAIL %s: got en_n=%b stat=%b chg=%b expected en_n=%b stat=%b chg=%b",
                             e.tag, pwr_en_n, oc_stat, oc_chg, e.en_n, e.st, e.ch);
                end
            end
        end
    end

    task automatic expect_out(string tag, logic [NP-1:0] en_n, logic [NP-1:0] st, logic [NP-1:0] ch);
        exp_t e;
        #1;
        e.tag = tag; e.en_n = en_n; e.st = st; e.ch = ch;
        exp_q.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic pulse(logic [NP-1:0] s, logic [NP-1:0] c, logic [NP-1:0] k);
        @(negedge clk);
        pwr_set_req = s; pwr_clr_req = c; chg_clr = k;
        @(negedge clk);
        pwr_set_req = '0; pwr_clr_req = '0; chg_clr = '0;
    endtask

    // Hold the given fault lines low for exactly n rising edges.
    task automatic fault(logic [NP-1:0] lines, int n);
        @(negedge clk);
        oc_in_n = ~lines;
        repeat (n) @(posedge clk);
        @(negedge clk);
        oc_in_n = '1;
    endtask

    task automatic fault_hold(logic [NP-1:0] lines, int n);
        @(negedge clk);
        oc_in_n = ~lines;
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        expect_out("R1 reset state", 3'b111, 3'b000, 3'b000);

        pulse(3'b001, 3'b000, 3'b000);
        expect_out("R2 set port0", 3'b110, 3'b000, 3'b000);
        pulse(3'b111, 3'b000, 3'b000);
        expect_out("R2 set all", 3'b000, 3'b000, 3'b000);
        pulse(3'b000, 3'b010, 3'b000);
        expect_out("R2 clear port1", 3'b010, 3'b000, 3'b000);
        pulse(3'b010, 3'b010, 3'b000);
        expect_out("R10 clear beats set", 3'b010, 3'b000, 3'b000);
        pulse(3'b010, 3'b000, 3'b000);
        expect_out("R2 set port1 again", 3'b000, 3'b000, 3'b000);

        // filt_len 3: 8 edges span exactly 2 ticks
        fault(3'b001, 2 * DV);
        settle(DV + 2);
        expect_out("R3 short pulse ignored", 3'b000, 3'b000, 3'b000);

        // 12 edges span exactly 3 ticks: accepted; R8 others untouched
        fault(3'b001, 3 * DV);
        settle(DV + 2);
        expect_out("R3 R8 boundary accepted, R6 stays off", 3'b001, 3'b000, 3'b001);
        pulse(3'b000, 3'b000, 3'b001);
        expect_out("R5 change cleared by host", 3'b001, 3'b000, 3'b000);

        fault_hold(3'b010, 4 * DV);
        expect_out("R4 R5 fault held on port1", 3'b011, 3'b010, 3'b010);
        pulse(3'b010, 3'b000, 3'b000);
        expect_out("R6 set ignored during fault", 3'b011, 3'b010, 3'b010);
        oc_in_n = '1;
        settle(DV + 2);
        expect_out("R5 change sticky after fault ends", 3'b011, 3'b000, 3'b010);
        pulse(3'b011, 3'b000, 3'b010);
        expect_out("R6 new set restores power", 3'b000, 3'b000, 3'b000);

        gang_en = 1'b1;
        pulse(3'b000, 3'b001, 3'b000);
        expect_out("R7 ganged clear", 3'b111, 3'b000, 3'b000);
        pulse(3'b100, 3'b000, 3'b000);
        expect_out("R7 ganged set", 3'b000, 3'b000, 3'b000);
        fault_hold(3'b100, 4 * DV);
        expect_out("R7 ganged trip", 3'b111, 3'b111, 3'b111);
        oc_in_n = '1;
        settle(DV + 2);
        pulse(3'b000, 3'b000, 3'b111);
        expect_out("R7 ganged recovery off", 3'b111, 3'b000, 3'b000);

        gang_en = 1'b0;
        two_port = 1'b1;
        pulse(3'b111, 3'b000, 3'b000);
        expect_out("R9 third port held off", 3'b100, 3'b000, 3'b000);
        fault_hold(3'b100, 4 * DV);
        expect_out("R9 third fault ignored", 3'b100, 3'b000, 3'b000);
        oc_in_n = '1;
        gang_en = 1'b1;
        fault_hold(3'b100, 4 * DV);
        expect_out("R9 third fault ignored ganged", 3'b100, 3'b000, 3'b000);
        oc_in_n = 3'b110;
        settle(4 * DV);
        expect_out("R9 R7 ganged two-port trip", 3'b111, 3'b011, 3'b011);
        oc_in_n = '1;
        settle(DV + 2);
        pulse(3'b000, 3'b000, 3'b111);

        gang_en = 1'b0;
        two_port = 1'b0;
        filt_len = '0;
        pulse(3'b111, 3'b000, 3'b000);
        expect_out("R2 per-port set all", 3'b000, 3'b000, 3'b000);
        fault(3'b010, DV);
        settle(DV + 2);
        expect_out("R3 zero length acts as one tick", 3'b010, 3'b000, 3'b010);

        settle(2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got no completion, expected end of sequence");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule